// File: doc/BRIEF.md
# Split Instruction/Data TLB with Maintenance Invalidation

This block is a small fully associative translation cache with two independent entry arrays, one serving instruction fetches and one serving data accesses. Each entry stores a 20-bit virtual page number, an 8-bit address-space tag, a physical page number, a valid flag and a lock flag. Both sides have a combinational lookup port. A lookup reports a hit and the stored physical page when an entry is valid, its page matches and its address-space tag equals the current address-space identifier.

Entries are written through a fill port. Each side keeps its own round-robin slot pointer. Entries are removed through a coprocessor-style maintenance write. The write carries a 4-bit CRm selector, a 3-bit opc2 selector and a 32-bit operand. CRm picks the target array or arrays and opc2 picks the kind of invalidation. A maintenance write takes effect at the clock edge that samples it, so a lookup in the following cycle already sees the result.

Top module: `tlb_maint`

## Requirements
- R1: After reset every entry on both sides is invalid, so no lookup hits.
- R2: A lookup hits only when the entry is valid, its page equals the lookup page and its tag equals `cur_asid`. On a hit, the lookup returns that entry's physical page. A matching page with a different tag misses.
- R3: Each side's fills go to slots in round-robin order 0, 1, …, ENTRIES-1, then back to 0. Once a side is full, the next fill to it replaces the oldest entry.
- R4: opc2 = 0 invalidates every unlocked entry in the target array. Entries whose lock flag is set stay valid.
- R5: opc2 = 1 invalidates entries whose page equals operand bits [31:12] and whose tag equals operand bits [7:0]. Both fields must match.
- R6: opc2 = 2 invalidates every entry whose tag equals operand bits [7:0], locked or not. Operand bits [31:8] are ignored.
- R7: opc2 = 3 invalidates every entry whose page equals operand bits [31:12], whatever its tag. Operand bits [11:0] are ignored.
- R8: CRm = 5 targets only the instruction array, CRm = 6 targets only the data array, and CRm = 7 targets both. An array that is not targeted is left unchanged.
- R9: A maintenance write with CRm outside 5..7, or with opc2 outside 0..3, leaves all entries on both sides unchanged.
- R10: A lookup in the cycle right after a maintenance write never hits an entry that the write invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_asid | input | 8 | Address-space identifier used by both lookups |
| mnt_valid | input | 1 | Maintenance write strobe |
| mnt_crm | input | 4 | Target selector (5 instruction, 6 data, 7 both) |
| mnt_opc2 | input | 3 | Operation selector (0 all unlocked, 1 page+tag, 2 tag, 3 page) |
| mnt_data | input | 32 | Operand: page in [31:12], tag in [7:0] |
| fill_valid | input | 1 | Fill strobe |
| fill_side | input | 1 | Fill target: 0 instruction, 1 data |
| fill_vpn | input | 20 | Virtual page to store |
| fill_asid | input | 8 | Tag to store |
| fill_ppn | input | PPN_W | Physical page to store |
| fill_lock | input | 1 | Lock flag to store |
| ilk_vpn | input | 20 | Instruction-side lookup page |
| ilk_hit | output | 1 | Instruction-side hit |
| ilk_ppn | output | PPN_W | Instruction-side physical page (zero on miss) |
| dlk_vpn | input | 20 | Data-side lookup page |
| dlk_hit | output | 1 | Data-side hit |
| dlk_ppn | output | PPN_W | Data-side physical page (zero on miss) |

## Verification
The bench builds the block with ENTRIES = 4 and PPN_W = 20. With four slots, a fifth fill wraps the round-robin pointer, and two pages crossed with two tags fill each array exactly. Half of each array is locked. Every opc2 value, 0 through 3, is applied to every target, CRm = 5, 6 and 7. After each write, six page/tag probes on both sides are compared with a model that is derived from the requirement rules. Illegal selector pairs and nonzero operand bits that must be ignored are swept as well.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
    localparam int VPN_W  = 20;
    localparam int ASID_W = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ALL_UNLOCKED,
        OP_PAGE_TAG,
        OP_TAG,
        OP_PAGE
    } maint_op_e;

    typedef struct packed {
        logic              tgt_i;
        logic              tgt_d;
        maint_op_e         op;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
    } maint_cmd_t;
endpackage

// File: rtl/tlb_maint_dec.sv
module tlb_maint_dec
    import tlb_maint_pkg::*;
(
    input  logic [3:0]  crm,
    input  logic [2:0]  opc2,
    input  logic [31:0] data,
    output maint_cmd_t  cmd
);
    logic unused_low;
    assign unused_low = ^data[11:8];

    always_comb begin
        cmd       = '0;
        cmd.op    = OP_NONE;
        cmd.vpn   = data[31:12];
        cmd.asid  = data[7:0];
        case (crm)
            4'd5: cmd.tgt_i = 1'b1;
            4'd6: cmd.tgt_d = 1'b1;
            4'd7: begin
                cmd.tgt_i = 1'b1;
                cmd.tgt_d = 1'b1;
            end
            default: ;
        endcase
        case (opc2)
            3'd0: cmd.op = OP_ALL_UNLOCKED;
            3'd1: cmd.op = OP_PAGE_TAG;
            3'd2: cmd.op = OP_TAG;
            3'd3: cmd.op = OP_PAGE;
            default: cmd.op = OP_NONE;
        endcase
        if (cmd.op == OP_NONE) begin
            cmd.tgt_i = 1'b0;
            cmd.tgt_d = 1'b0;
        end
    end
endmodule

// File: rtl/tlb_maint_side.sv
module tlb_maint_side
    import tlb_maint_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PPN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  maint_cmd_t        cmd,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_lock,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0]             lock;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        logic [PTR_W-1:0]               ptr;
    } side_state_t;

    side_state_t st_d, st_q;
    logic [ENTRIES-1:0] match;

    // Next-state: maintenance first, then the fill overrides its own slot.
    always_comb begin
        st_d = st_q;
        if (cmd_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                case (cmd.op)
                    OP_ALL_UNLOCKED: if (!st_q.lock[i]) st_d.valid[i] = 1'b0;
                    OP_PAGE_TAG: if (st_q.vpn[i] == cmd.vpn && st_q.asid[i] == cmd.asid)
                        st_d.valid[i] = 1'b0;
                    OP_TAG:  if (st_q.asid[i] == cmd.asid) st_d.valid[i] = 1'b0;
                    OP_PAGE: if (st_q.vpn[i] == cmd.vpn)   st_d.valid[i] = 1'b0;
                    default: ;
                endcase
            end
        end
        if (fill_en) begin
            st_d.valid[st_q.ptr] = 1'b1;
            st_d.lock[st_q.ptr]  = fill_lock;
            st_d.vpn[st_q.ptr]   = fill_vpn;
            st_d.asid[st_q.ptr]  = fill_asid;
            st_d.ppn[st_q.ptr]   = fill_ppn;
            st_d.ptr = (st_q.ptr == PTR_LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = st_q.valid[g] && (st_q.vpn[g] == lk_vpn)
                          && (st_q.asid[g] == cur_asid);
    end

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) lk_ppn = lk_ppn | st_q.ppn[i];
    end
    assign lk_hit = |match;
endmodule

// File: rtl/tlb_maint.sv
module tlb_maint
    import tlb_maint_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PPN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cur_asid,
    input  logic              mnt_valid,
    input  logic [3:0]        mnt_crm,
    input  logic [2:0]        mnt_opc2,
    input  logic [31:0]       mnt_data,
    input  logic              fill_valid,
    input  logic              fill_side,
    input  logic [19:0]       fill_vpn,
    input  logic [7:0]        fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_lock,
    input  logic [19:0]       ilk_vpn,
    output logic              ilk_hit,
    output logic [PPN_W-1:0]  ilk_ppn,
    input  logic [19:0]       dlk_vpn,
    output logic              dlk_hit,
    output logic [PPN_W-1:0]  dlk_ppn
);
    maint_cmd_t cmd;
    logic [1:0][VPN_W-1:0] lk_vpn;
    logic [1:0]            lk_hit;
    logic [1:0][PPN_W-1:0] lk_ppn;
    logic [1:0]            tgt;

    tlb_maint_dec dec_i (
        .crm  (mnt_crm),
        .opc2 (mnt_opc2),
        .data (mnt_data),
        .cmd  (cmd)
    );

    assign tgt    = {cmd.tgt_d, cmd.tgt_i};
    assign lk_vpn = {dlk_vpn, ilk_vpn};

    // Side 0 is the instruction array, side 1 the data array.
    for (genvar s = 0; s < 2; s++) begin : g_side
        tlb_maint_side #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) side_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_en    (mnt_valid && tgt[s]),
            .cmd       (cmd),
            .fill_en   (fill_valid && (fill_side == 1'(s))),
            .fill_vpn  (fill_vpn),
            .fill_asid (fill_asid),
            .fill_ppn  (fill_ppn),
            .fill_lock (fill_lock),
            .cur_asid  (cur_asid),
            .lk_vpn    (lk_vpn[s]),
            .lk_hit    (lk_hit[s]),
            .lk_ppn    (lk_ppn[s])
        );
    end

    assign ilk_hit = lk_hit[0];
    assign ilk_ppn = lk_ppn[0];
    assign dlk_hit = lk_hit[1];
    assign dlk_ppn = lk_ppn[1];
endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk #(
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cur_asid,
    input logic             mnt_valid,
    input logic [3:0]       mnt_crm,
    input logic [2:0]       mnt_opc2,
    input logic [31:0]      mnt_data,
    input logic             fill_valid,
    input logic [19:0]      ilk_vpn,
    input logic             ilk_hit,
    input logic [PPN_W-1:0] ilk_ppn,
    input logic [19:0]      dlk_vpn,
    input logic             dlk_hit,
    input logic [PPN_W-1:0] dlk_ppn
);
    logic legal_sel;
    assign legal_sel = (mnt_crm >= 4'd5) && (mnt_crm <= 4'd7) && (mnt_opc2 <= 3'd3);

    logic quiet_mnt;
    assign quiet_mnt = mnt_valid && !fill_valid;

    logic unused_chk;
    assign unused_chk = ^{mnt_data[11:8], ilk_ppn};

    // R1: first cycle out of reset has no hits
    assert_reset_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!ilk_hit && !dlk_hit));

    // R5 / R10: page+tag invalidation on data side
    assert_page_tag_gone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mnt && mnt_crm == 4'd6 && mnt_opc2 == 3'd1) |=>
        (dlk_vpn != $past(mnt_data[31:12]) || cur_asid != $past(mnt_data[7:0]) || !dlk_hit));

    // R6 / R10: tag invalidation on data side
    assert_tag_gone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mnt && mnt_crm == 4'd6 && mnt_opc2 == 3'd2) |=>
        (cur_asid != $past(mnt_data[7:0]) || !dlk_hit));

    // R7 / R10: page invalidation on instruction side, any tag
    assert_page_gone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mnt && mnt_crm == 4'd5 && mnt_opc2 == 3'd3) |=>
        (ilk_vpn != $past(mnt_data[31:12]) || !ilk_hit));

    // R8: instruction-only write leaves data lookups unchanged
    assert_other_side_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mnt && mnt_crm == 4'd5) |=>
        (!$stable(dlk_vpn) || !$stable(cur_asid) ||
         (dlk_hit == $past(dlk_hit) && dlk_ppn == $past(dlk_ppn))));

    // R9: illegal selector pair changes nothing
    assert_illegal_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mnt && !legal_sel) |=>
        (!$stable(dlk_vpn) || !$stable(ilk_vpn) || !$stable(cur_asid) ||
         (dlk_hit == $past(dlk_hit) && ilk_hit == $past(ilk_hit))));
endmodule

bind tlb_maint tlb_maint_chk #(.PPN_W(PPN_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_asid   (cur_asid),
    .mnt_valid  (mnt_valid),
    .mnt_crm    (mnt_crm),
    .mnt_opc2   (mnt_opc2),
    .mnt_data   (mnt_data),
    .fill_valid (fill_valid),
    .ilk_vpn    (ilk_vpn),
    .ilk_hit    (ilk_hit),
    .ilk_ppn    (ilk_ppn),
    .dlk_vpn    (dlk_vpn),
    .dlk_hit    (dlk_hit),
    .dlk_ppn    (dlk_ppn)
);

// File: tb/tlb_maint_tb.sv
module tlb_maint_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int PW = 20;

    localparam logic [19:0] PG_A = 20'h12345;
    localparam logic [19:0] PG_B = 20'hABCDE;
    localparam logic [19:0] PG_C = 20'h0F0F0;
    localparam logic [7:0]  TG_X = 8'h11;
    localparam logic [7:0]  TG_Y = 8'h22;
    localparam logic [7:0]  TG_Z = 8'h33;

    logic clk = 0;
    logic rst_n = 0;
    logic [7:0]  cur_asid = 0;
    logic        mnt_valid = 0;
    logic [3:0]  mnt_crm = 0;
    logic [2:0]  mnt_opc2 = 0;
    logic [31:0] mnt_data = 0;
    logic        fill_valid = 0;
    logic        fill_side = 0;
    logic [19:0] fill_vpn = 0;
    logic [7:0]  fill_asid = 0;
    logic [PW-1:0] fill_ppn = 0;
    logic        fill_lock = 0;
    logic [19:0] ilk_vpn = 0, dlk_vpn = 0;
    logic        ilk_hit, dlk_hit;
    logic [PW-1:0] ilk_ppn, dlk_ppn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model built from the requirement rules
    bit          m_valid [2][N];
    bit          m_lock  [2][N];
    logic [19:0] m_vpn   [2][N];
    logic [7:0]  m_tag   [2][N];
    logic [PW-1:0] m_ppn [2][N];
    int          m_ptr   [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_maint #(.ENTRIES(N), .PPN_W(PW)) dut_i (.*);

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int s = 0; s < 2; s++) begin
            m_ptr[s] = 0;
            for (int k = 0; k < N; k++) m_valid[s][k] = 0;
        end
    endtask

    task automatic do_fill(input bit side, input logic [19:0] vpn, input logic [7:0] tag,
                           input logic [PW-1:0] ppn, input bit lck);
        @(negedge clk);
        fill_valid = 1; fill_side = side; fill_vpn = vpn;
        fill_asid = tag; fill_ppn = ppn; fill_lock = lck;
        @(negedge clk);
        fill_valid = 0;
        m_valid[side][m_ptr[side]] = 1;
        m_lock[side][m_ptr[side]]  = lck;
        m_vpn[side][m_ptr[side]]   = vpn;
        m_tag[side][m_ptr[side]]   = tag;
        m_ppn[side][m_ptr[side]]   = ppn;
        m_ptr[side] = (m_ptr[side] + 1) % N;
    endtask

    task automatic do_maint(input logic [3:0] crm, input logic [2:0] opc, input logic [31:0] data);
        bit ti, td;
        @(negedge clk);
        mnt_valid = 1; mnt_crm = crm; mnt_opc2 = opc; mnt_data = data;
        @(negedge clk);
        mnt_valid = 0;
        ti = (crm == 5 || crm == 7) && opc <= 3;
        td = (crm == 6 || crm == 7) && opc <= 3;
        for (int s = 0; s < 2; s++) begin
            if ((s == 0 && ti) || (s == 1 && td)) begin
                for (int k = 0; k < N; k++) begin
                    bit pm, tm;
                    pm = m_vpn[s][k] == data[31:12];
                    tm = m_tag[s][k] == data[7:0];
                    case (opc)
                        3'd0: if (!m_lock[s][k]) m_valid[s][k] = 0;
                        3'd1: if (pm && tm) m_valid[s][k] = 0;
                        3'd2: if (tm) m_valid[s][k] = 0;
                        3'd3: if (pm) m_valid[s][k] = 0;
                        default: ;
                    endcase
                end
            end
        end
    endtask

    task automatic probe(input string tag, input logic [19:0] vpn, input logic [7:0] asid);
        bit eh [2];
        logic [PW-1:0] ep [2];
        ilk_vpn = vpn; dlk_vpn = vpn; cur_asid = asid;
        #1;
        for (int s = 0; s < 2; s++) begin
            eh[s] = 0; ep[s] = '0;
            for (int k = 0; k < N; k++)
                if (m_valid[s][k] && m_vpn[s][k] == vpn && m_tag[s][k] == asid) begin
                    eh[s] = 1; ep[s] = m_ppn[s][k];
                end
        end
        checks++;
        if (ilk_hit !== eh[0] || ilk_ppn !== ep[0]) begin
            errors++;
            $display("FAIL %s instr vpn=%h asid=%h: hit=%0b ppn=%h expected hit=%0b ppn=%h",
                     tag, vpn, asid, ilk_hit, ilk_ppn, eh[0], ep[0]);
        end
        checks++;
        if (dlk_hit !== eh[1] || dlk_ppn !== ep[1]) begin
            errors++;
            $display("FAIL %s data vpn=%h asid=%h: hit=%0b ppn=%h expected hit=%0b ppn=%h",
                     tag, vpn, asid, dlk_hit, dlk_ppn, eh[1], ep[1]);
        end
    endtask

    task automatic probe_all(input string tag);
        probe(tag, PG_A, TG_X);
        probe(tag, PG_B, TG_X);
        probe(tag, PG_A, TG_Y);
        probe(tag, PG_B, TG_Y);
        probe(tag, PG_C, TG_X);
        probe(tag, PG_A, TG_Z);
    endtask

    // Pattern: slot k holds page A/B by k[0], tag X/Y by k[1]; slots 1 and 2 locked
    task automatic populate();
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < N; k++)
                do_fill(s[0], k[0] ? PG_B : PG_A, k[1] ? TG_Y : TG_X,
                        PW'(32'h100 * (s + 1) + k), (k == 1 || k == 2));
    endtask

    initial begin
        do_reset();
        probe_all("R1 reset all miss");

        populate();
        probe_all("R2 fill and lookup");

        for (int c = 5; c <= 7; c++) begin
            for (int op = 0; op < 4; op++) begin
                logic [31:0] d;
                string t;
                do_reset();
                populate();
                case (op)
                    0: begin d = 32'h0;                         t = "R4/R8/R10 all-unlocked"; end
                    1: begin d = {PG_A, 4'h0, TG_Y};            t = "R5/R8/R10 page+tag"; end
                    2: begin d = {24'hFEDCBA, TG_X};            t = "R6/R8/R10 tag"; end
                    default: begin d = {PG_B, 12'hFA5};         t = "R7/R8/R10 page any tag"; end
                endcase
                do_maint(4'(c), 3'(op), d);
                probe_all($sformatf("%s crm=%0d", t, c));
            end
        end

        // R9: illegal selector pairs leave everything as it was
        do_reset();
        populate();
        do_maint(4'd5, 3'd4, 32'h0);
        do_maint(4'd8, 3'd0, 32'h0);
        do_maint(4'd6, 3'd5, {PG_A, 4'h0, TG_X});
        do_maint(4'd4, 3'd2, {24'h0, TG_X});
        do_maint(4'd7, 3'd7, {PG_B, 12'h0});
        do_maint(4'd0, 3'd3, {PG_A, 12'h0});
        probe_all("R9 illegal ignored");

        // R3: fifth fill to the data side replaces slot 0
        do_reset();
        populate();
        do_fill(1'b1, PG_C, TG_X, PW'(32'h999), 1'b0);
        probe_all("R3 round-robin wrap");
        do_fill(1'b1, PG_C, TG_Z, PW'(32'h777), 1'b0);
        probe(     "R3 second wrap", PG_C, TG_Z);
        probe(     "R3 second wrap", PG_B, TG_X);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule